// File: doc/BRIEF.md
# USB Role and Session Override Unit

This block lets software take over the role-detect and session indications that a USB2 PHY normally takes from its analog comparators and its ID pin. Each command is a single-cycle strobe with a 3-bit opcode. Three opcodes choose the role: device, host, or OTG, where OTG follows the live ID pin. Two opcodes bring the session up or down. All other opcode values are ignored.

The block holds a 10-bit control word with five meaningful bits. It also drives an enable for the VBUS comparator and an effective ID output. A role command rewrites only the two ID bits of the word. A session command rewrites only the three session bits and the comparator enable. When the force bit is clear, the effective ID is the ID pin after a two-flop synchronizer.

Top module: `usb_role_override`

## Requirements
- R1: Opcode 3'd1 (device) sets the force-ID bit and the forced ID value to 1. The new values are visible after the clock edge that samples the command.
- R2: Opcode 3'd2 (host) sets the force-ID bit to 1 and the forced ID value to 0.
- R3: Opcode 3'd3 (OTG) clears both the force-ID bit and the forced ID value.
- R4: Opcode values 3'd0, 3'd6 and 3'd7 leave the control word and the comparator enable unchanged. The same holds for any cycle with cmd_valid low.
- R5: Opcode 3'd4 (power-on) does all of the following: sets the comparator enable to 1, sets VBUS-valid and A-valid to 1, and clears session-end.
- R6: Opcode 3'd5 (power-off) does all of the following: clears the comparator enable, clears VBUS-valid and A-valid, and sets session-end.
- R7: The control word has force-ID at bit 9, VBUS-valid at bit 5, session-end at bit 4, A-valid at bit 2 and the forced ID value at bit 1. Every other bit reads 0.
- R8: Role commands do not change the session bits or the comparator enable. Session commands do not change the two ID bits.
- R9: While force-ID is 1, the effective ID output equals the forced ID value.
- R10: While force-ID is 0, the effective ID output follows the ID pin. A change on the pin shows after exactly two clock edges.
- R11: After reset, the control word is 0x010, which means OTG role with session-end set. The comparator enable is 0, and the effective ID reads 1 until the pin propagates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| id_pin | input | 1 | Raw ID pin, asynchronous |
| ctrl_word | output | 10 | Override control word |
| vbus_cmp_en | output | 1 | VBUS comparator enable |
| id_eff | output | 1 | Effective ID seen by the controller |

## Verification
The role commands are tried in several sequences: device then host, host then OTG, and repeats of the same role. Each sequence is run with the session both up and down. This separates a correct ID-bit update from one that leaks into the session bits, and the reverse. The ID pin is toggled under each role. A forced role must mask the pin, while OTG must show the pin exactly two edges later, which exposes a wrong synchronizer depth. Illegal opcodes and idle cycles are issued from non-reset states, so that a decoder treating them as a valid command becomes visible in the word.

// File: rtl/usb_role_override.sv
module usb_role_override #(
  parameter int  WORD_W    = 10,
  parameter int  OP_W      = 3,
  parameter bit  ID_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              id_pin,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              vbus_cmp_en,
  output logic              id_eff
);
  localparam int B_FORCE = 9;
  localparam int B_VBUS  = 5;
  localparam int B_SEND  = 4;
  localparam int B_AVAL  = 2;
  localparam int B_IDV   = 1;

  localparam logic [OP_W-1:0] OP_DEV  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_HOST = OP_W'(2);
  localparam logic [OP_W-1:0] OP_OTG  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_PON  = OP_W'(4);
  localparam logic [OP_W-1:0] OP_POFF = OP_W'(5);

  logic force_q, idv_q, vbus_q, aval_q, send_q, cmp_q;
  logic sync1_q, sync2_q;

  wire is_role = cmd_valid && (cmd_op == OP_DEV || cmd_op == OP_HOST || cmd_op == OP_OTG);
  wire is_sess = cmd_valid && (cmd_op == OP_PON || cmd_op == OP_POFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      idv_q   <= 1'b0;
    end else if (is_role) begin
      force_q <= (cmd_op != OP_OTG);
      idv_q   <= (cmd_op == OP_DEV);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_q <= 1'b0;
      aval_q <= 1'b0;
      send_q <= 1'b1;
      cmp_q  <= 1'b0;
    end else if (is_sess) begin
      vbus_q <= (cmd_op == OP_PON);
      aval_q <= (cmd_op == OP_PON);
      send_q <= (cmd_op == OP_POFF);
      cmp_q  <= (cmd_op == OP_PON);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= ID_RST;
      sync2_q <= ID_RST;
    end else begin
      sync1_q <= id_pin;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[B_FORCE] = force_q;
    ctrl_word[B_VBUS]  = vbus_q;
    ctrl_word[B_SEND]  = send_q;
    ctrl_word[B_AVAL]  = aval_q;
    ctrl_word[B_IDV]   = idv_q;
  end

  assign vbus_cmp_en = cmp_q;
  assign id_eff      = force_q ? idv_q : sync2_q;

  AST_ROLE_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_DEV |=> ctrl_word[B_FORCE] && ctrl_word[B_IDV]); // R1
  AST_ROLE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_HOST |=> ctrl_word[B_FORCE] && !ctrl_word[B_IDV]); // R2
  AST_ROLE_OTG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_OTG |=> !ctrl_word[B_FORCE] && !ctrl_word[B_IDV]); // R3
  AST_NOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_role && !is_sess |=> $stable(ctrl_word) && $stable(vbus_cmp_en)); // R4
  AST_PWR_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PON |=> vbus_cmp_en && ctrl_word[B_VBUS] && ctrl_word[B_AVAL] && !ctrl_word[B_SEND]); // R5
  AST_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_POFF |=> !vbus_cmp_en && !ctrl_word[B_VBUS] && !ctrl_word[B_AVAL] && ctrl_word[B_SEND]); // R6
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_word) == $countones(ctrl_word & WORD_W'(10'h236))); // R7
  AST_ROLE_KEEPS_SESS: assert property (@(posedge clk) disable iff (!rst_n)
    is_role |=> $stable(vbus_cmp_en) && $stable(ctrl_word[B_VBUS]) && $stable(ctrl_word[B_AVAL]) && $stable(ctrl_word[B_SEND])); // R8
  AST_SESS_KEEPS_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_sess |=> $stable(ctrl_word[B_FORCE]) && $stable(ctrl_word[B_IDV])); // R8
  AST_FORCED_ID: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[B_FORCE] |-> id_eff == ctrl_word[B_IDV]); // R9
endmodule

// File: tb/usb_role_override_test.sv
module usb_role_override_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       id_pin = 1'b1;
  logic [9:0] ctrl_word;
  logic       vbus_cmp_en;
  logic       id_eff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit e_force = 0, e_idv = 0, e_vbus = 0, e_aval = 0, e_send = 1, e_cmp = 0;

  always #10 clk = ~clk;

  usb_role_override uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .id_pin(id_pin), .ctrl_word(ctrl_word), .vbus_cmp_en(vbus_cmp_en), .id_eff(id_eff)
  );

  function automatic logic [9:0] exp_word();
    logic [9:0] w = '0;
    w[9] = e_force; w[5] = e_vbus; w[4] = e_send; w[2] = e_aval; w[1] = e_idv;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    case (op)
      3'd1: begin e_force = 1; e_idv = 1; end
      3'd2: begin e_force = 1; e_idv = 0; end
      3'd3: begin e_force = 0; e_idv = 0; end
      3'd4: begin e_cmp = 1; e_vbus = 1; e_aval = 1; e_send = 0; end
      3'd5: begin e_cmp = 0; e_vbus = 0; e_aval = 0; e_send = 1; end
      default: ;
    endcase
  endtask

  task automatic chk_state(string req);
    chk(req, 32'(ctrl_word), 32'(exp_word()));
    chk(req, 32'(vbus_cmp_en), 32'(e_cmp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 word", 32'(ctrl_word), 32'h010);
    chk("R11 cmp", 32'(vbus_cmp_en), 32'd0);
    chk("R11 id", 32'(id_eff), 32'd1);
  endtask

  task automatic t_roles;
    issue(3'd1); chk_state("R1 device"); chk("R9 dev id", 32'(id_eff), 32'd1);
    chk("R7 layout", 32'(ctrl_word), 32'h212);
    issue(3'd2); chk_state("R2 host"); chk("R9 host id", 32'(id_eff), 32'd0);
    chk("R7 layout host", 32'(ctrl_word), 32'h210);
    issue(3'd2); chk_state("R2 repeat");
    issue(3'd3); chk_state("R3 otg");
  endtask

  task automatic t_session;
    issue(3'd4); chk_state("R5 power-on");
    chk("R7 layout on", 32'(ctrl_word), 32'h024);
    issue(3'd1); chk_state("R8 role keeps session");
    issue(3'd5); chk_state("R6 power-off");
    chk("R8 session keeps role", 32'(ctrl_word[9]), 32'd1);
    issue(3'd4); issue(3'd2); chk_state("R8 host while on");
    chk("R7 layout host on", 32'(ctrl_word), 32'h224);
  endtask

  task automatic t_ignored;
    issue(3'd0); chk_state("R4 op0");
    issue(3'd6); chk_state("R4 op6");
    issue(3'd7); chk_state("R4 op7");
    @(negedge clk); cmd_op = 3'd1; @(negedge clk); cmd_op = 3'd0;
    chk_state("R4 no valid");
  endtask

  task automatic t_id_pin;
    issue(3'd2);
    @(negedge clk); id_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 pin masked", 32'(id_eff), 32'd0);
    issue(3'd3);
    chk("R10 pin high", 32'(id_eff), 32'd1);
    id_pin = 1'b0;
    @(negedge clk); chk("R10 one edge", 32'(id_eff), 32'd1);
    @(negedge clk); chk("R10 two edges", 32'(id_eff), 32'd0);
    id_pin = 1'b1;
    @(negedge clk); chk("R10 rise one edge", 32'(id_eff), 32'd0);
    @(negedge clk); chk("R10 rise two edges", 32'(id_eff), 32'd1);
    issue(3'd2); chk("R9 host over pin", 32'(id_eff), 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_roles();
    t_session();
    t_ignored();
    t_id_pin();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule